// File: doc/BRIEF.md
# DMA Transfer Address and Length Sequencer

This block steps one DMA channel through a transfer once its configuration has been decoded. A start pulse loads the source and destination base addresses and the per-side address modes. The data path then sends one step strobe for each completed transfer. On each strobe the block moves both pointers by their own mode, counts down the remaining transfers, flags the final transfer, and gives a one-cycle done pulse when the count runs out.

The count is either a fixed value taken at start or a variable value. A variable count is read from the first source byte. The step that reads this length byte moves only the source pointer. Its value sets how many transfers follow. For byte transfers a mode bit picks 7 or 8 bits of that byte. For word transfers all 8 bits are always used. At completion an interrupt flag is set if the channel's mask bit was 1. A request leaves the block only while the global enable is also 1.

Top module: `xfer_addr_seq`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, busy, done, last, irq_flag and irq_req are 0, and both addresses are 0.
- R2: Each side moves its pointer on the clock edge that samples an accepted step. The mode codes are 00 = hold, 01 = +1, 10 = +2 and 11 = −1. Addresses wrap modulo 2^16. Each side uses the mode latched at start, independently of the other side.
- R3: With fixed length N > 0, the transfer phase accepts exactly N steps. `last` is 1 while one transfer remains in the transfer phase, and 0 at all other times.
- R4: `done` is 1 for exactly one cycle, the cycle after the edge that completes the transfer. By then busy is 0.
- R5: In variable-length mode the first step is the length step. It reads `rd_data` and moves only the source pointer. For byte transfers, `len8_sel` = 1 takes all 8 bits as the count and `len8_sel` = 0 takes bits 6:0.
- R6: For word transfers (`word_xfer` = 1), `len8_sel` is ignored and all 8 bits of the length byte give the count.
- R7: A count of zero ends the transfer with no transfer phase. A fixed length of 0 gives done in the cycle after start. A variable length byte that yields 0 gives done in the cycle after the length step.
- R8: At completion `irq_flag` is set if the latched mask bit is 1. `irq_clr` clears the flag, and a set in the same cycle wins. `irq_req` equals `irq_flag` AND `irq_en`.
- R9: A start while busy is ignored. A step while idle is ignored. Neither one changes the addresses or the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin (accepted when idle) |
| src_base | input | 16 | Source start address |
| dst_base | input | 16 | Destination start address |
| src_mode | input | 2 | Source address mode (00 hold, 01 +1, 10 +2, 11 −1) |
| dst_mode | input | 2 | Destination address mode |
| len_var | input | 1 | 1 = length from the first source byte |
| len_fixed | input | 13 | Fixed transfer count |
| word_xfer | input | 1 | 1 = word transfers |
| len8_sel | input | 1 | 1 = 8-bit variable length, 0 = 7-bit |
| irq_mask | input | 1 | Set the interrupt flag at completion |
| irq_en | input | 1 | Global interrupt enable |
| irq_clr | input | 1 | Clear the interrupt flag |
| step | input | 1 | One transfer done at the current addresses |
| rd_data | input | 8 | Source byte, read as the length on the length step |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |
| busy | output | 1 | Transfer in progress |
| last | output | 1 | Current transfer is the final one |
| done | output | 1 | One-cycle completion pulse |
| irq_flag | output | 1 | Interrupt flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the rules that hold locally. A held pointer does not move. The counter never steps below zero. `last` and `done` appear only in their own phases. A request never shows without its flag. An idle block does not move. Only the bench's scenarios can show that the count comes out right from the 7-bit, 8-bit and word readings of the length byte. The same goes for addresses wrapping across the 16-bit boundary, for zero lengths ending in the right cycle, and for a start during a transfer being ignored. The bench compares all of these against its behavioural model on every clock.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        AM_HOLD = 2'b00,
        AM_INC1 = 2'b01,
        AM_INC2 = 2'b10,
        AM_DEC1 = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEN  = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    typedef struct packed {
        logic [1:0] src_mode;
        logic [1:0] dst_mode;
        logic       word_xfer;
        logic       len8_sel;
        logic       irq_mask;
    } chan_cfg_t;

    localparam int N_SIDES = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    // signed per-transfer delta for a mode code
    function automatic logic signed [2:0] mode_delta(input logic [1:0] m);
        case (addr_mode_e'(m))
            AM_INC1: return 3'sd1;
            AM_INC2: return 3'sd2;
            AM_DEC1: return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
    import xfer_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [1:0]    mode,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    logic signed [2:0] delta;
    logic [AW-1:0]     delta_ext;

    always_comb begin
        delta     = mode_delta(mode);
        delta_ext = {{(AW-3){delta[2]}}, delta};
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= base;
        else if (adv)  ptr <= ptr + delta_ext;
    end

    assert_hold_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && mode == 2'b00) |=> $stable(ptr));

    assert_idle_still_R9: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(ptr));
endmodule

// File: rtl/xfer_len_count.sv
module xfer_len_count #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          one_left
);
    logic [CW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)       rem_q <= '0;
        else if (load) rem_q <= load_val;
        else if (dec)  rem_q <= rem_q - 1'b1;
    end

    assign one_left = (rem_q == CW'(1));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (rem_q != '0));
endmodule

// File: rtl/xfer_irq_flag.sv
module xfer_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
    import xfer_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 13,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic          len_var,
    input  logic [CW-1:0] len_fixed,
    input  logic          word_xfer,
    input  logic          len8_sel,
    input  logic          irq_mask,
    input  logic          irq_en,
    input  logic          irq_clr,
    input  logic          step,
    input  logic [LW-1:0] rd_data,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          busy,
    output logic          last,
    output logic          done,
    output logic          irq_flag,
    output logic          irq_req
);
    localparam int PADW = CW - LW;

    phase_e    phase_q, phase_d;
    chan_cfg_t cfg_q;
    logic      start_ok, len_step, xfer_step, cnt_last, finish, zero_fixed, zero_var;
    logic      cnt_load, fin_mask;
    logic [LW-1:0] var_len;
    logic [CW-1:0] cnt_val;
    logic [AW-1:0] side_base [N_SIDES];
    logic [1:0]    side_mode [N_SIDES];
    logic          side_adv  [N_SIDES];
    logic [AW-1:0] side_ptr  [N_SIDES];

    always_comb begin
        start_ok   = start && (phase_q == PH_IDLE);
        len_step   = step && (phase_q == PH_LEN);
        xfer_step  = step && (phase_q == PH_XFER);
        var_len    = (cfg_q.word_xfer || cfg_q.len8_sel) ? rd_data
                                                         : {1'b0, rd_data[LW-2:0]};
        zero_fixed = (len_fixed == '0);
        zero_var   = (var_len == '0);
        cnt_load   = (start_ok && !len_var) || len_step;
        cnt_val    = start_ok ? len_fixed : {{PADW{1'b0}}, var_len};
        finish     = (start_ok && !len_var && zero_fixed) || (len_step && zero_var)
                   || (xfer_step && cnt_last);
        fin_mask   = start_ok ? irq_mask : cfg_q.irq_mask;

        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (start_ok)
                         phase_d = len_var ? PH_LEN : (zero_fixed ? PH_IDLE : PH_XFER);
            PH_LEN:  if (len_step)
                         phase_d = zero_var ? PH_IDLE : PH_XFER;
            PH_XFER: if (xfer_step && cnt_last)
                         phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= finish;
            if (start_ok)
                cfg_q <= '{src_mode: src_mode, dst_mode: dst_mode, word_xfer: word_xfer,
                           len8_sel: len8_sel, irq_mask: irq_mask};
        end
    end

    always_comb begin
        side_base[SIDE_SRC] = src_base;
        side_base[SIDE_DST] = dst_base;
        side_mode[SIDE_SRC] = cfg_q.src_mode;
        side_mode[SIDE_DST] = cfg_q.dst_mode;
        side_adv[SIDE_SRC]  = len_step || xfer_step;
        side_adv[SIDE_DST]  = xfer_step;
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        xfer_addr_step #(.AW(AW)) u_step (
            .clk  (clk),
            .rst  (rst),
            .load (start_ok),
            .base (side_base[s]),
            .mode (side_mode[s]),
            .adv  (side_adv[s]),
            .ptr  (side_ptr[s])
        );
    end

    xfer_len_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (xfer_step),
        .one_left (cnt_last)
    );

    xfer_irq_flag u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (finish && fin_mask),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign src_addr = side_ptr[SIDE_SRC];
    assign dst_addr = side_ptr[SIDE_DST];
    assign busy     = (phase_q != PH_IDLE);
    assign last     = (phase_q == PH_XFER) && cnt_last;
    assign irq_req  = irq_flag && irq_en;

    assert_last_in_xfer_R3: assert property (@(posedge clk) disable iff (rst)
        last |-> busy);
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_req_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_flag);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> ($stable(src_addr) && $stable(dst_addr)));
    assert_len_src_only_R5: assert property (@(posedge clk) disable iff (rst)
        (len_step) |=> $stable(dst_addr));
endmodule

// File: tb/tb_xfer_addr_seq.sv
module tb_xfer_addr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 0, len_var = 0, word_xfer = 0, len8_sel = 0;
    logic        irq_mask = 0, irq_en = 0, irq_clr = 0, step = 0;
    logic [15:0] src_base = 0, dst_base = 0;
    logic [1:0]  src_mode = 0, dst_mode = 0;
    logic [12:0] len_fixed = 0;
    logic [7:0]  rd_data = 0;
    logic [15:0] src_addr, dst_addr;
    logic        busy, last, done, irq_flag, irq_req;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xfer_addr_seq dut (.*);

    // behavioural reference model
    int m_phase = 0, m_src = 0, m_dst = 0, m_rem = 0;
    int m_smode = 0, m_dmode = 0;
    bit m_word = 0, m_l8 = 0, m_mask = 0, m_done = 0, m_flag = 0;

    function automatic int adv(input int a, input int m);
        int r;
        case (m)
            1: r = a + 1;
            2: r = a + 2;
            3: r = a - 1;
            default: r = a;
        endcase
        return r & 32'hFFFF;
    endfunction

    always @(posedge clk) begin
        bit d;
        int n;
        d = 0;
        if (rst) begin
            m_phase = 0; m_src = 0; m_dst = 0; m_rem = 0; m_flag = 0;
        end else begin
            if (m_phase == 0 && start) begin
                m_src = src_base; m_dst = dst_base;
                m_smode = src_mode; m_dmode = dst_mode;
                m_word = word_xfer; m_l8 = len8_sel; m_mask = irq_mask;
                if (len_var) m_phase = 1;
                else if (len_fixed == 0) d = 1;
                else begin m_rem = len_fixed; m_phase = 2; end
            end else if (m_phase == 1 && step) begin
                m_src = adv(m_src, m_smode);
                n = (m_word || m_l8) ? int'(rd_data) : int'(rd_data) % 128;
                if (n == 0) begin d = 1; m_phase = 0; end
                else begin m_rem = n; m_phase = 2; end
            end else if (m_phase == 2 && step) begin
                m_src = adv(m_src, m_smode);
                m_dst = adv(m_dst, m_dmode);
                if (m_rem == 1) begin d = 1; m_phase = 0; end
                m_rem = m_rem - 1;
            end
            if (d && m_mask) m_flag = 1;
            else if (irq_clr) m_flag = 0;
        end
        m_done = d;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R2 src_addr", src_addr, m_src);
            chk("R2 dst_addr", dst_addr, m_dst);
            chk("R9 busy", busy, m_phase != 0);
            chk("R3 last", last, (m_phase == 2) && (m_rem == 1));
            chk("R4 done", done, m_done);
            chk("R8 irq_flag", irq_flag, m_flag);
            chk("R8 irq_req", irq_req, m_flag && irq_en);
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic kick(input logic [15:0] sb, input logic [15:0] db, input logic [1:0] sm,
                        input logic [1:0] dm, input logic lv, input int lf,
                        input logic w, input logic l8, input logic mk);
        cyc();
        src_base = sb; dst_base = db; src_mode = sm; dst_mode = dm;
        len_var = lv; len_fixed = 13'(lf); word_xfer = w; len8_sel = l8; irq_mask = mk;
        start = 1;
        cyc();
        start = 0;
    endtask

    task automatic run_steps(input int gap);
        for (int k = 0; k < 1000; k++) begin
            cyc();
            if (done) begin step = 0; return; end
            step = (gap == 0) || (k % gap != 0);
        end
        step = 0;
    endtask

    initial begin
        repeat (3) cyc();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset src", src_addr, 0);
        rst = 0;
        cyc();
        chk("R1 after release done", done, 0);
        chk("R1 after release irq", irq_flag, 0);

        // R2 R3: fixed 4, src +1, dst +2
        kick(16'h1000, 16'h2000, 2'b01, 2'b10, 0, 4, 0, 0, 0);
        run_steps(0);
        chk("R2 fixed src end", src_addr, 16'h1004);
        chk("R3 fixed dst end", dst_addr, 16'h2008);

        // R2 wrap, R8 interrupt, gapped steps
        irq_en = 1;
        kick(16'hFFFF, 16'h0000, 2'b01, 2'b11, 0, 3, 0, 0, 1);
        run_steps(3);
        chk("R2 wrap src", src_addr, 16'h0002);
        chk("R2 wrap dst", dst_addr, 16'hFFFD);
        cyc();
        chk("R8 irq_req raised", irq_req, 1);
        irq_en = 0;
        cyc();
        chk("R8 irq_req gated", irq_req, 0);
        irq_clr = 1;
        cyc();
        irq_clr = 0;
        chk("R8 flag cleared", irq_flag, 0);

        // R5 7-bit length: 0x85 -> 5
        rd_data = 8'h85;
        kick(16'h0100, 16'h0300, 2'b10, 2'b00, 1, 0, 0, 0, 0);
        run_steps(0);
        chk("R5 7-bit src end", src_addr, 16'h010C);
        chk("R5 hold dst", dst_addr, 16'h0300);

        // R5 8-bit length: 0x85 -> 133
        kick(16'h0000, 16'h0400, 2'b01, 2'b01, 1, 0, 0, 1, 0);
        run_steps(2);
        chk("R5 8-bit src end", src_addr, 16'h0086);
        chk("R5 8-bit dst end", dst_addr, 16'h0485);

        // R6 word transfers ignore len8_sel
        kick(16'h0200, 16'h0000, 2'b11, 2'b00, 1, 0, 1, 0, 0);
        run_steps(0);
        chk("R6 word src end", src_addr, 16'h017A);

        // R7 variable zero, mask 0
        rd_data = 8'h80;
        kick(16'h0500, 16'h0600, 2'b01, 2'b01, 1, 0, 0, 0, 0);
        step = 1;
        cyc();
        step = 0;
        chk("R7 var zero done", done, 1);
        chk("R7 var zero src", src_addr, 16'h0501);
        chk("R8 no flag when masked", irq_flag, 0);

        // R7 fixed zero
        kick(16'h0700, 16'h0800, 2'b01, 2'b01, 0, 0, 0, 0, 1);
        chk("R7 fixed zero done", done, 1);
        chk("R7 fixed zero idle", busy, 0);
        cyc();
        chk("R4 single pulse", done, 0);

        // R9 start while busy, step while idle
        kick(16'h0A00, 16'h0B00, 2'b01, 2'b01, 0, 2, 0, 0, 0);
        start = 1; src_base = 16'hDEAD;
        cyc();
        start = 0;
        chk("R9 start ignored", src_addr, 16'h0A00);
        run_steps(0);
        step = 1;
        repeat (3) cyc();
        step = 0;
        chk("R9 idle step ignored", src_addr, 16'h0A02);
        repeat (2) cyc();
        finish_run();
    end
endmodule